// File: doc/BRIEF.md
# Multiprocessor Interrupt Level Controller

This block gathers interrupt requests for a small multiprocessor with up to four CPUs. It turns them into a processor interrupt level between 1 and 15 for each CPU. It takes 32 level-sensitive device request lines and one timer line per CPU. A fixed table gives the level for each device line. Device levels go only to the one CPU picked as the routing target. They are also held off by a global disable bit and by a per-line disable bit.

Each CPU also has a local pending register. This register holds fifteen software interrupt bits, a level-15 flag and a level-14 timer flag. The level-15 flag is broadcast: any device line whose level is 15 raises it on every CPU at once, and each CPU may drop it by itself. The timer flag follows that CPU's own timer line. Both flags bypass all disabling.

For each CPU the block drives two outputs:
- a 15-bit vector of the active levels;
- the number of the highest active level.

A simple write/read register port changes the disable bits, the target, and the software and flag bits.

Top module: `mp_irq_level_ctrl`

## Requirements
- R1: Device lines 0..31 map to levels 2,3,5,7,9,11,13,2,3,5,7,9,11,13,12,12,6,13,4,10,8,9,11,0,0,0,0,15,15,15,15,0. On `cpu_lvl_vec`, bit k-1 stands for level k. Each CPU owns a 15-bit slice of that port, CPU c at bits 15c+14..15c.
- R2: A device line whose table level is 0 (lines 23..26 and 31) never sets any level bit.
- R3: A device line adds its level only to the CPU equal to the target register, and only when two conditions hold. Bit 31 of the disable register must be 0. The line's own bit in the disable register must also be 0.
- R4: A rising edge on any level-15 device line (27..30) sets the level-15 flag of every CPU. A falling edge on any of them clears the flag on every CPU, unless another of those lines rises in the same cycle.
- R5: A CPU's timer line drives that CPU's level-14 flag one cycle later. It affects no other CPU and ignores every disable bit. The level-15 flag also ignores every disable bit.
- R6: A write to the set-soft address of CPU c (address 9+2c) ORs data bits 31..17 into its software bits. Data bits 16..0 are ignored. Software bit 16+k drives level k.
- R7: A write to the clear address of CPU c (address 8+2c) first ANDs the data with 0xFFFE8000. Every remaining 1 clears the matching bit of that CPU's pending register. The timer flag (bit 14) is never cleared this way.
- R8: Device levels are computed again every cycle from the lines that are asserted now. Dropping one line keeps a level that another asserted, enabled line still maps to.
- R9: After reset the disable register reads 0x0FA2007F, the target is 0, and all pending state reads 0. All level outputs are 0.
- R10: `cpu_lvl_enc` for CPU c (bits 4c+3..4c) gives the highest set bit position plus 1 of that CPU's level vector, or 0 when the vector is empty.
- R11: Register map:
  - Address 1 ORs the data into the disable register.
  - Address 2 clears the disable bits where the data holds a 1.
  - Address 3 loads data bits 1..0 into the target register.
  - Addresses 0..2 read the disable register.
  - Address 3 reads the target.
  - Address 4 reads the sampled device lines.
  - Addresses 5..7 read 0.
- R12: Reading address 8+2c or 9+2c returns CPU c's pending word:
  - software bits at bits 31..17;
  - bit 16 as 0;
  - the level-15 flag at bit 15 and the timer flag at bit 14;
  - bit 0 as 0.
  
  When c is the target, each asserted device line with a non-zero level also sets the bit whose position equals its level. This happens whatever the disable bits hold.

  All level outputs show a change one clock edge after the input or write that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_irq | input | 32 | Level-sensitive device request lines |
| cpu_timer | input | NUM_CPU | One timer request line per CPU |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| cpu_lvl_vec | output | 15*NUM_CPU | Active-level vector per CPU |
| cpu_lvl_enc | output | 4*NUM_CPU | Highest active level per CPU |

## Verification
A wrong flag or routing state shows up on the level vector and the encoded level one clock edge after the stimulus. Because the pending registers can be read back, such a fault can also be seen there. A level-15 flag that is lost on one CPU, or kept after its source falls, differs from the expected vector on the very next compared cycle. Mapping or mask faults show up as a wrong bit as soon as the line concerned is driven. A level that drops too early when lines share it appears at the same edge as the deassertion.

// File: rtl/irqlvl_pkg.sv
package irqlvl_pkg;
  localparam int DEV_N     = 32;
  localparam int LVL_N     = 15;
  localparam int ENC_W     = 4;
  localparam int TGT_W     = 2;
  localparam int ADDR_W    = 4;
  localparam int DW        = 32;
  localparam int SOFT_LO   = 17;
  localparam int SOFT_N    = DW - SOFT_LO;
  localparam logic [DW-1:0] DIS_RESET = 32'h0FA2_007F;
  localparam logic [DW-1:0] CLR_KEEP  = 32'hFFFE_8000;

  // fixed line-to-level table; 0 means the line is unused
  function automatic logic [ENC_W-1:0] dev_level(input int idx);
    logic [ENC_W-1:0] l;
    case (idx)
      0, 7:             l = 4'd2;
      1, 8:             l = 4'd3;
      2, 9:             l = 4'd5;
      3, 10:            l = 4'd7;
      4, 11, 21:        l = 4'd9;
      5, 12, 22:        l = 4'd11;
      6, 13, 17:        l = 4'd13;
      14, 15:           l = 4'd12;
      16:               l = 4'd6;
      18:               l = 4'd4;
      19:               l = 4'd10;
      20:               l = 4'd8;
      27, 28, 29, 30:   l = 4'd15;
      default:          l = 4'd0;
    endcase
    return l;
  endfunction

  // lines whose table level is the top level
  function automatic logic [DEV_N-1:0] top_lines();
    logic [DEV_N-1:0] m;
    m = '0;
    for (int i = 0; i < DEV_N; i++)
      if (dev_level(i) == 4'(LVL_N)) m[i] = 1'b1;
    return m;
  endfunction

  // highest active level, 0 when none
  function automatic logic [ENC_W-1:0] top_level(input logic [LVL_N-1:0] v);
    logic [ENC_W-1:0] r;
    r = '0;
    for (int k = 0; k < LVL_N; k++)
      if (v[k]) r = ENC_W'(k + 1);
    return r;
  endfunction
endpackage

// File: rtl/irq_master_regs.sv
module irq_master_regs
  import irqlvl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEV_N-1:0] dev_in,
  input  logic             mask_set_we,
  input  logic             mask_clr_we,
  input  logic             tgt_we,
  input  logic [DW-1:0]    wdata,
  output logic [DEV_N-1:0] dev_q,
  output logic [DW-1:0]    dis_q,
  output logic [TGT_W-1:0] tgt_q,
  output logic             top_rise,
  output logic             top_fall
);
  localparam logic [DEV_N-1:0] TOP_M = top_lines();

  assign top_rise = |(dev_in & ~dev_q & TOP_M);
  assign top_fall = |(~dev_in & dev_q & TOP_M);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_q <= '0;
      dis_q <= DIS_RESET;
      tgt_q <= '0;
    end else begin
      dev_q <= dev_in;
      if (mask_set_we)      dis_q <= dis_q | wdata;
      else if (mask_clr_we) dis_q <= dis_q & ~wdata;
      if (tgt_we) tgt_q <= wdata[TGT_W-1:0];
    end
  end

  // R11: target only moves on its own write
  a_r11_tgt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_we |=> $stable(tgt_q));
  // R3: set-mask write makes the written bits disable bits
  a_r3_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    mask_set_we |=> ((dis_q & $past(wdata)) == $past(wdata)));
endmodule

// File: rtl/irq_lvl_decode.sv
module irq_lvl_decode
  import irqlvl_pkg::*;
(
  input  logic [DEV_N-1:0] lines,
  output logic [LVL_N-1:0] lvls
);
  logic [LVL_N-1:0] contrib [DEV_N];

  for (genvar i = 0; i < DEV_N; i++) begin : g_line
    localparam logic [ENC_W-1:0] LV = dev_level(i);
    if (LV != 0) begin : g_used
      assign contrib[i] = lines[i] ? (LVL_N'(1) << (LV - 1)) : '0;
    end else begin : g_unused
      assign contrib[i] = '0;
    end
  end

  always_comb begin
    lvls = '0;
    for (int i = 0; i < DEV_N; i++) lvls = lvls | contrib[i];
  end
endmodule

// File: rtl/irq_cpu_slice.sv
module irq_cpu_slice
  import irqlvl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              timer_in,
  input  logic              top_rise,
  input  logic              top_fall,
  input  logic              clr_we,
  input  logic              set_we,
  input  logic [SOFT_N-1:0] w_soft,
  input  logic              w_top,
  input  logic              is_target,
  input  logic [LVL_N-1:0]  route_lvls,
  input  logic [LVL_N-1:0]  disp_lvls,
  output logic [LVL_N-1:0]  lvl_vec,
  output logic [ENC_W-1:0]  lvl_enc,
  output logic [DW-1:0]     pend_rd
);
  logic [SOFT_N-1:0] soft_q;
  logic              top_q;
  logic              tmr_q;
  logic [LVL_N-1:0]  dev_part;
  logic [LVL_N-1:0]  disp_part;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soft_q <= '0;
      top_q  <= 1'b0;
      tmr_q  <= 1'b0;
    end else begin
      tmr_q <= timer_in;
      if (top_rise)              top_q <= 1'b1;
      else if (top_fall)         top_q <= 1'b0;
      else if (clr_we && w_top)  top_q <= 1'b0;
      if (set_we)      soft_q <= soft_q | w_soft;
      else if (clr_we) soft_q <= soft_q & ~w_soft;
    end
  end

  assign dev_part  = is_target ? route_lvls : '0;
  assign disp_part = is_target ? disp_lvls  : '0;
  assign lvl_vec   = dev_part | soft_q | {top_q, tmr_q, {(LVL_N-2){1'b0}}};
  assign lvl_enc   = top_level(lvl_vec);
  assign pend_rd   = {soft_q, 1'b0, top_q | disp_part[14], tmr_q | disp_part[13],
                      disp_part[12:0], 1'b0};

  // R5: timer shows as level 14 after one edge
  a_r5_timer_lvl: assert property (@(posedge clk) disable iff (!rst_n)
    timer_in |=> lvl_vec[13]);
  // R4: broadcast rise reaches this CPU
  a_r4_top_rise: assert property (@(posedge clk) disable iff (!rst_n)
    top_rise |=> lvl_vec[14]);
  // R4: fall without rise drops the local flag
  a_r4_top_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (top_fall && !top_rise) |=> !pend_rd[15] || is_target);
  // R7: local clear of the flag works when no rise competes
  a_r7_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && w_top && !top_rise) |=> (!pend_rd[15] || is_target));
  // R10: encoder zero and top
  a_r10_enc_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_vec == '0) |-> (lvl_enc == '0));
  a_r10_enc_top: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_enc != '0) |-> (lvl_vec[lvl_enc - 4'd1] && ((lvl_vec >> lvl_enc) == '0)));
endmodule

// File: rtl/mp_irq_level_ctrl.sv
module mp_irq_level_ctrl
  import irqlvl_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [DEV_N-1:0]         dev_irq,
  input  logic [NUM_CPU-1:0]       cpu_timer,
  input  logic                     reg_we,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [DW-1:0]            reg_wdata,
  output logic [DW-1:0]            reg_rdata,
  output logic [LVL_N*NUM_CPU-1:0] cpu_lvl_vec,
  output logic [ENC_W*NUM_CPU-1:0] cpu_lvl_enc
);
  logic [DEV_N-1:0] dev_q;
  logic [DW-1:0]    dis_q;
  logic [TGT_W-1:0] tgt_q;
  logic             top_rise, top_fall;
  logic [DEV_N-1:0] route_lines;
  logic [LVL_N-1:0] route_lvls, disp_lvls;
  logic [DW-1:0]    pend_rd [NUM_CPU];
  logic             cpu_space;
  logic [TGT_W-1:0] sel_cpu;

  assign cpu_space = reg_addr[ADDR_W-1];
  assign sel_cpu   = reg_addr[TGT_W:1];

  irq_master_regs u_master (
    .clk(clk), .rst_n(rst_n), .dev_in(dev_irq),
    .mask_set_we(reg_we && reg_addr == 4'd1),
    .mask_clr_we(reg_we && reg_addr == 4'd2),
    .tgt_we(reg_we && reg_addr == 4'd3),
    .wdata(reg_wdata),
    .dev_q(dev_q), .dis_q(dis_q), .tgt_q(tgt_q),
    .top_rise(top_rise), .top_fall(top_fall)
  );

  assign route_lines = dev_q & ~dis_q & {DEV_N{~dis_q[DW-1]}};

  irq_lvl_decode u_route (.lines(route_lines), .lvls(route_lvls));
  irq_lvl_decode u_disp  (.lines(dev_q),       .lvls(disp_lvls));

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic hit;
    assign hit = reg_we && cpu_space && (sel_cpu == TGT_W'(c));
    irq_cpu_slice u_slice (
      .clk(clk), .rst_n(rst_n),
      .timer_in(cpu_timer[c]),
      .top_rise(top_rise), .top_fall(top_fall),
      .clr_we(hit && !reg_addr[0]),
      .set_we(hit && reg_addr[0]),
      .w_soft(reg_wdata[DW-1:SOFT_LO]),
      .w_top(reg_wdata[LVL_N]),
      .is_target(tgt_q == TGT_W'(c)),
      .route_lvls(route_lvls), .disp_lvls(disp_lvls),
      .lvl_vec(cpu_lvl_vec[c*LVL_N +: LVL_N]),
      .lvl_enc(cpu_lvl_enc[c*ENC_W +: ENC_W]),
      .pend_rd(pend_rd[c])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (cpu_space) begin
      for (int c = 0; c < NUM_CPU; c++)
        if (sel_cpu == TGT_W'(c)) reg_rdata = pend_rd[c];
    end else begin
      case (reg_addr[2:0])
        3'd0, 3'd1, 3'd2: reg_rdata = dis_q;
        3'd3:             reg_rdata = DW'(tgt_q);
        3'd4:             reg_rdata = dev_q;
        default:          reg_rdata = '0;
      endcase
    end
  end

  // R2: unused lines never reach the decoded levels
  a_r2_unused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((dev_q & 32'h8780_0000) == dev_q) |-> (route_lvls == '0 && disp_lvls == '0));
  // R3: global disable blocks all device levels
  a_r3_global_off: assert property (@(posedge clk) disable iff (!rst_n)
    dis_q[DW-1] |-> (route_lvls == '0));
endmodule

// File: tb/mp_irq_level_ctrl_bench.sv
`timescale 1ns/1ps
module mp_irq_level_ctrl_bench;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   dev_irq = '0;
  logic [NC-1:0] cpu_timer = '0;
  logic          reg_we = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [15*NC-1:0] cpu_lvl_vec;
  logic [4*NC-1:0]  cpu_lvl_enc;

  mp_irq_level_ctrl #(.NUM_CPU(NC)) u_mp_irq_level_ctrl (
    .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .cpu_timer(cpu_timer),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cpu_lvl_vec(cpu_lvl_vec), .cpu_lvl_enc(cpu_lvl_enc)
  );

  always #4 clk = ~clk;

  // reference table, written by level groups then laid out per line
  int lvl_of [32];
  initial begin
    for (int i = 0; i < 32; i++) lvl_of[i] = 0;
    lvl_of[16] = 6;  lvl_of[18] = 4;  lvl_of[19] = 10; lvl_of[20] = 8;
    lvl_of[14] = 12; lvl_of[15] = 12; lvl_of[17] = 13; lvl_of[21] = 9; lvl_of[22] = 11;
    for (int i = 27; i <= 30; i++) lvl_of[i] = 15;
    for (int i = 0; i < 7; i++) begin
      lvl_of[i]     = (i == 0) ? 2 : (i == 1) ? 3 : 2 * i + 1;
      lvl_of[i + 7] = lvl_of[i];
    end
  end

  // reference state
  logic [31:0] m_dev, m_dis;
  logic [1:0]  m_tgt;
  logic [14:0] m_soft [NC];
  logic        m_top [NC];
  logic        m_tmr [NC];

  typedef struct {
    logic [15*NC-1:0] vec;
    logic [4*NC-1:0]  enc;
    bit               chk_rd;
    logic [31:0]      rd;
    string            tag;
  } item_t;
  item_t sbq[$];

  int total = 0;
  int bad = 0;
  bit done = 0;

  function automatic logic [14:0] ref_vec(int c);
    logic [14:0] v;
    v = m_soft[c];
    if (m_tmr[c]) v[13] = 1'b1;
    if (m_top[c]) v[14] = 1'b1;
    if (c == int'(m_tgt) && !m_dis[31])
      for (int i = 0; i < 31; i++)
        if (m_dev[i] && !m_dis[i] && lvl_of[i] != 0) v[lvl_of[i]-1] = 1'b1;
    return v;
  endfunction

  function automatic logic [3:0] ref_enc(logic [14:0] v);
    for (int k = 14; k >= 0; k--) if (v[k]) return 4'(k + 1);
    return 4'd0;
  endfunction

  function automatic logic [31:0] ref_rd(logic [3:0] a);
    logic [31:0] r;
    int c;
    if (a[3]) begin
      c = int'(a[2:1]);
      r = {m_soft[c], 1'b0, m_top[c], m_tmr[c], 14'd0};
      if (c == int'(m_tgt))
        for (int i = 0; i < 32; i++)
          if (m_dev[i] && lvl_of[i] != 0) r[lvl_of[i]] = 1'b1;
      return r;
    end
    case (a[2:0])
      3'd0, 3'd1, 3'd2: return m_dis;
      3'd3: return {30'd0, m_tgt};
      3'd4: return m_dev;
      default: return 32'd0;
    endcase
  endfunction

  task automatic push_expect(string tag, bit chk);
    item_t it;
    for (int c = 0; c < NC; c++) begin
      it.vec[c*15 +: 15] = ref_vec(c);
      it.enc[c*4 +: 4]   = ref_enc(ref_vec(c));
    end
    it.chk_rd = chk;
    it.rd = ref_rd(reg_addr);
    it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic finish_step(string tag, bit chk);
    @(posedge clk);
    #1 reg_we = 1'b0;
    push_expect(tag, chk);
  endtask

  task automatic drive_dev(logic [31:0] nv, string tag);
    logic rise, fall;
    @(posedge clk);
    #2 dev_irq = nv;
    rise = 1'b0; fall = 1'b0;
    for (int i = 27; i <= 30; i++) begin
      if (nv[i] && !m_dev[i]) rise = 1'b1;
      if (!nv[i] && m_dev[i]) fall = 1'b1;
    end
    for (int c = 0; c < NC; c++)
      if (rise) m_top[c] = 1'b1; else if (fall) m_top[c] = 1'b0;
    m_dev = nv;
    finish_step(tag, 1'b0);
  endtask

  task automatic drive_timer(logic [NC-1:0] nv, string tag);
    @(posedge clk);
    #2 cpu_timer = nv;
    for (int c = 0; c < NC; c++) m_tmr[c] = nv[c];
    finish_step(tag, 1'b0);
  endtask

  task automatic reg_write(logic [3:0] a, logic [31:0] d, string tag);
    int c;
    logic [31:0] k;
    @(posedge clk);
    #2 reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    c = int'(a[2:1]);
    if (a[3] && a[0]) m_soft[c] = m_soft[c] | d[31:17];
    else if (a[3]) begin
      k = d & 32'hFFFE_8000;
      m_soft[c] = m_soft[c] & ~k[31:17];
      if (k[15]) m_top[c] = 1'b0;
    end
    else if (a == 4'd1) m_dis = m_dis | d;
    else if (a == 4'd2) m_dis = m_dis & ~d;
    else if (a == 4'd3) m_tgt = d[1:0];
    finish_step(tag, 1'b0);
  endtask

  task automatic reg_read(logic [3:0] a, string tag);
    @(posedge clk);
    #2 reg_addr = a;
    finish_step(tag, 1'b1);
  endtask

  // monitor: compare every queued item at the falling edge
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      while (sbq.size() > 0) begin
        it = sbq.pop_front();
        for (int c = 0; c < NC; c++) begin
          total++;
          if (cpu_lvl_vec[c*15 +: 15] !== it.vec[c*15 +: 15] ||
              cpu_lvl_enc[c*4 +: 4] !== it.enc[c*4 +: 4]) begin
            bad++;
            $display("FAIL %s cpu%0d vec=%h enc=%0d expected vec=%h enc=%0d", it.tag, c,
                     cpu_lvl_vec[c*15 +: 15], cpu_lvl_enc[c*4 +: 4],
                     it.vec[c*15 +: 15], it.enc[c*4 +: 4]);
          end
        end
        if (it.chk_rd) begin
          total++;
          if (reg_rdata !== it.rd) begin
            bad++;
            $display("FAIL %s rdata=%h expected %h", it.tag, reg_rdata, it.rd);
          end
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_dev = '0; m_dis = 32'h0FA2_007F; m_tgt = '0;
    for (int c = 0; c < NC; c++) begin m_soft[c] = '0; m_top[c] = 0; m_tmr[c] = 0; end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R9 reset state and disable value
    reg_read(4'd0, "R9 reset disable");
    reg_read(4'd8, "R9 reset pending cpu0");
    reg_read(4'd3, "R9 reset target");
    // R11 clear every disable bit
    reg_write(4'd2, 32'hFFFF_FFFF, "R11 clear mask");
    reg_read(4'd1, "R11 disable readback");
    // R1 mapping of several lines
    drive_dev(32'h0000_0001, "R1 line0 level2");
    drive_dev(32'h0009_0001, "R1 lines 16 19");
    drive_dev(32'h0040_4000, "R1 lines 14 22");
    drive_dev(32'h0017_0000, "R1 lines 16 17 18 20");
    // R8 shared level survives one line dropping
    drive_dev(32'h0000_0081, "R8 lines 0 7");
    drive_dev(32'h0000_0080, "R8 line0 dropped");
    drive_dev(32'h0000_0000, "R8 all dropped");
    // R3 routing to target
    drive_dev(32'h0008_0204, "R3 lines 2 9 19");
    reg_write(4'd3, 32'h0000_0002, "R3 target cpu2");
    reg_read(4'd3, "R11 target readback");
    reg_read(4'd4, "R11 device readback");
    reg_read(4'd12, "R12 pending cpu2 target");
    reg_read(4'd8, "R12 pending cpu0 not target");
    reg_write(4'd1, 32'h8000_0000, "R3 global disable");
    reg_read(4'd12, "R12 pending ignores disable");
    reg_write(4'd2, 32'h8000_0000, "R3 global enable");
    reg_write(4'd1, 32'h0008_0000, "R3 line19 masked");
    reg_write(4'd2, 32'h0008_0000, "R3 line19 unmasked");
    // R2 unused lines
    drive_dev(32'h8780_0000, "R2 zero-level lines");
    reg_read(4'd12, "R2 pending with zero-level lines");
    drive_dev(32'h0000_0000, "R2 released");
    // R4 broadcast top level
    drive_dev(32'h1000_0000, "R4 line28 rise");
    reg_read(4'd10, "R4 pending cpu1 flag");
    drive_dev(32'h0000_0000, "R4 line28 fall");
    drive_dev(32'h2800_0000, "R4 lines 27 29 rise");
    reg_write(4'd10, 32'h0000_8000, "R7 cpu1 clears flag");
    drive_dev(32'h2000_0000, "R4 line27 fall clears all");
    drive_dev(32'h0000_0000, "R4 all released");
    // R5 timer bypasses disable
    reg_write(4'd1, 32'hFFFF_FFFF, "R5 disable all");
    drive_timer(4'b1000, "R5 timer cpu3");
    drive_dev(32'h4000_0001, "R5 flag under disable");
    reg_read(4'd14, "R12 pending cpu3 timer");
    reg_write(4'd14, 32'hFFFF_FFFF, "R7 clear keeps timer");
    reg_read(4'd14, "R7 pending cpu3 after clear");
    drive_timer(4'b0000, "R5 timer off");
    drive_dev(32'h0000_0000, "R5 lines off");
    // R6 software levels
    reg_write(4'd11, 32'hFFFF_FFFF, "R6 cpu1 all soft");
    reg_write(4'd10, 32'h00FE_0000, "R7 cpu1 clear low soft");
    reg_read(4'd10, "R12 pending cpu1 soft");
    reg_write(4'd13, 32'h0001_FFFF, "R6 low bits ignored");
    reg_read(4'd12, "R6 cpu2 unchanged");
    reg_write(4'd9, 32'h0002_0000, "R6 cpu0 level1");
    reg_write(4'd10, 32'hFFFF_FFFF, "R10 cpu1 empty");
    reg_write(4'd8, 32'hFFFF_FFFF, "R10 cpu0 empty");
    @(posedge clk);
    @(negedge clk);
    #1;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule